// File: doc/BRIEF.md
# Cumulative Heat Release Calculator

This block converts a stream of cylinder pressure samples into a running cumulative heat release figure, one result per sample. Each incoming word carries an unsigned 12-bit pressure value, a crank-angle index and a cycle-start flag. The index selects a cylinder volume and a volume increment from two on-chip tables, which are filled through a simple write port before use. The block never differentiates pressure. It combines the present pressure-volume product, a reference product captured at the start of the cycle and a running sum of pressure times volume increment:

Q(k) = (KA·p(k)·V(k) − KB·p0·V0 + KC·Σ p(i)·dV(i)) >>> SHIFT

The weights KA, KB and KC are fixed signed integer parameters worked out offline. SHIFT sets the fixed-point scaling. With the default scaling, one output step is roughly 3.85 J and one pressure step is roughly 1465 Pa.

Both stream interfaces use valid/ready. The back-pressure rule is `in_ready = !out_valid || out_ready`, and it is combinational. When the result register holds an unaccepted word, every pipeline stage freezes, including the table read. An upstream source may raise `in_valid` without waiting for `in_ready`, but it must hold the payload while `in_valid && !in_ready`. A downstream sink sees `out_heat` held steady for as long as `out_valid && !out_ready`.

Top module: `heat_release_pipe`

## Requirements
- R1: While reset is asserted and after it is released, with no input accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: When the output is never stalled, the result for a sample accepted at rising edge n is presented with `out_valid` high after rising edge n+LAT−1, where LAT = 12. In other words, LAT edges are counted including the accepting edge.
- R3: Each result equals the formula above, with these interpretations:
  - p is unsigned.
  - V(k) is the unsigned volume entry and dV(k) is the two's-complement increment entry at index k.
  - `>>>` is an arithmetic right shift that rounds toward minus infinity.
  - `out_heat` is two's complement.
- R4: A sample accepted with `in_start` = 1 latches its own p·V as the reference p0·V0. It also loads the running sum with its own p·dV, discarding earlier history.
- R5: The running sum saturates at the limits of its signed width, 2·P_W + 1 + ACC_GUARD bits, instead of wrapping.
- R6: The shifted result saturates to the range −2048 … +2047 of the 12-bit output.
- R7: `in_ready` equals `!out_valid || out_ready`. A stalled output word stays unchanged, and every accepted sample yields exactly one result, in order.
- R8: A table write at index i changes V(i) and dV(i) for every sample accepted after the write.
- R9: A cycle with `in_valid` low produces no result and leaves the reference and the running sum unchanged, whatever `in_start`, `in_press` and `in_crank` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken on this edge when `in_valid` is also high |
| in_press | input | 12 | Unsigned pressure sample |
| in_crank | input | AW (10) | Crank-angle index into the tables |
| in_start | input | 1 | Marks the first sample of an engine cycle |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts the result |
| out_heat | output | 12 | Signed cumulative heat release |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW (10) | Table write index |
| tbl_vol | input | 12 | Unsigned volume entry to write |
| tbl_dvol | input | 12 | Signed volume increment entry to write |

## Verification
The hardest condition to reach is saturation of the running sum. Under ordinary scaling, the output clip hides it, because a clipped sum still produces an output already stuck at its limit. The bench therefore uses a narrow sum guard and a unit weight on the sum. It latches a small reference, then repeatedly feeds mid-range pressure at the index with the largest positive increment, and later at the index with the most negative one. The sum pins at each limit while the output stays inside its own range, so a wrapping sum would show up directly in `out_heat`. Back-pressure is covered by a pseudo-random ready pattern and by a long hold with ready low, during which the frozen pipeline must drop `in_ready` and then release every queued result in order.

// File: rtl/hr_pkg.sv
package hr_pkg;

  // Stages between input and the scaled result: table read, products,
  // accumulate, weight, sum, shift/clip.
  localparam int HR_CORE_STAGES = 6;

  // Clip a signed value to the range of a w-bit two's-complement word.
  function automatic logic signed [63:0] clip_signed(input logic signed [63:0] x,
                                                     input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

endpackage

// File: rtl/hr_table.sv
module hr_table #(
  parameter int AW  = 10,
  parameter int V_W = 12,
  parameter int D_W = 12
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [V_W-1:0]        wr_vol,
  input  logic signed [D_W-1:0] wr_dvol,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [V_W-1:0]        rd_vol,
  output logic signed [D_W-1:0] rd_dvol
);
  localparam int DEPTH = 1 << AW;

  logic [V_W-1:0]        vol_mem  [DEPTH];
  logic signed [D_W-1:0] dvol_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vol_mem[wr_addr]  <= wr_vol;
      dvol_mem[wr_addr] <= wr_dvol;
    end
    if (rd_en) begin
      rd_vol  <= vol_mem[rd_addr];
      rd_dvol <= dvol_mem[rd_addr];
    end
  end
endmodule

// File: rtl/hr_accum.sv
module hr_accum #(
  parameter int PV_W  = 25,
  parameter int PD_W  = 25,
  parameter int ACC_W = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    v_in,
  input  logic                    start,
  input  logic signed [PV_W-1:0]  pv_in,
  input  logic signed [PD_W-1:0]  pdv_in,
  output logic                    v_out,
  output logic signed [PV_W-1:0]  pv_out,
  output logic signed [PV_W-1:0]  ref_out,
  output logic signed [ACC_W-1:0] acc_out
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0]   acc_wide;
  logic signed [ACC_W-1:0] acc_next;

  always_comb begin
    acc_wide = {acc_out[ACC_W-1], acc_out} + (ACC_W+1)'(pdv_in);
    if (acc_wide[ACC_W] != acc_wide[ACC_W-1])
      acc_next = acc_wide[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      acc_next = acc_wide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      pv_out  <= '0;
      ref_out <= '0;
      acc_out <= '0;
    end else if (en) begin
      v_out  <= v_in;
      pv_out <= pv_in;
      if (v_in) begin
        if (start) begin
          ref_out <= pv_in;
          acc_out <= ACC_W'(pdv_in);
        end else begin
          acc_out <= acc_next;
        end
      end
    end
  end

  AST_REF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && start |=> ref_out == $past(pv_in)); // R4
  AST_ACC_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && !start && !pdv_in[PD_W-1] |=> acc_out >= $past(acc_out)); // R5
  AST_ACC_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    en && v_in && !start && pdv_in[PD_W-1] |=> acc_out <= $past(acc_out)); // R5
  AST_IDLE_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    !v_in |=> $stable(acc_out) && $stable(ref_out)); // R9
endmodule

// File: rtl/hr_scale.sv
module hr_scale import hr_pkg::*; #(
  parameter int PV_W  = 25,
  parameter int ACC_W = 36,
  parameter int K_W   = 16,
  parameter int SUM_W = 54,
  parameter int SHIFT = 16,
  parameter int Q_W   = 12,
  parameter int KA    = 10,
  parameter int KB    = 12,
  parameter int KC    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    v_in,
  input  logic signed [PV_W-1:0]  pv_in,
  input  logic signed [PV_W-1:0]  ref_in,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic                    v_out,
  output logic [Q_W-1:0]          q_out
);
  localparam logic signed [K_W-1:0] KA_C = K_W'(KA);
  localparam logic signed [K_W-1:0] KB_C = K_W'(KB);
  localparam logic signed [K_W-1:0] KC_C = K_W'(KC);

  logic                    w_v, s_v;
  logic signed [SUM_W-1:0] term_a, term_b, term_c, total;
  logic signed [SUM_W-1:0] shifted;
  logic signed [63:0]      clipped;

  assign shifted = total >>> SHIFT;
  assign clipped = clip_signed(64'(shifted), Q_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_v    <= 1'b0;
      s_v    <= 1'b0;
      v_out  <= 1'b0;
      term_a <= '0;
      term_b <= '0;
      term_c <= '0;
      total  <= '0;
      q_out  <= '0;
    end else if (en) begin
      w_v    <= v_in;
      term_a <= SUM_W'(KA_C) * SUM_W'(pv_in);
      term_b <= SUM_W'(KB_C) * SUM_W'(ref_in);
      term_c <= SUM_W'(KC_C) * SUM_W'(acc_in);
      s_v    <= w_v;
      total  <= term_a - term_b + term_c;
      v_out  <= s_v;
      q_out  <= Q_W'(clipped);
    end
  end
endmodule

// File: rtl/heat_release_pipe.sv
module heat_release_pipe import hr_pkg::*; #(
  parameter int P_W       = 12,
  parameter int AW        = 10,
  parameter int V_W       = 12,
  parameter int D_W       = 12,
  parameter int K_W       = 16,
  parameter int ACC_GUARD = 11,
  parameter int SHIFT     = 16,
  parameter int LAT       = 12,
  parameter int Q_W       = 12,
  parameter int KA        = 10,
  parameter int KB        = 12,
  parameter int KC        = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [P_W-1:0]        in_press,
  input  logic [AW-1:0]         in_crank,
  input  logic                  in_start,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [Q_W-1:0]        out_heat,
  input  logic                  tbl_we,
  input  logic [AW-1:0]         tbl_addr,
  input  logic [V_W-1:0]        tbl_vol,
  input  logic signed [D_W-1:0] tbl_dvol
);
  localparam int PV_W  = P_W + V_W + 1;
  localparam int PD_W  = P_W + D_W + 1;
  localparam int ACC_W = PD_W + ACC_GUARD;
  localparam int SUM_W = ACC_W + K_W + 2;
  localparam int PAD   = LAT - HR_CORE_STAGES;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: table read alongside the pressure word
  logic [V_W-1:0]        t_vol;
  logic signed [D_W-1:0] t_dvol;
  logic                  s1_v, s1_st;
  logic [P_W-1:0]        s1_p;

  hr_table #(.AW(AW), .V_W(V_W), .D_W(D_W)) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_vol  (tbl_vol),
    .wr_dvol (tbl_dvol),
    .rd_en   (adv),
    .rd_addr (in_crank),
    .rd_vol  (t_vol),
    .rd_dvol (t_dvol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_st <= 1'b0;
      s1_p  <= '0;
    end else if (adv) begin
      s1_v  <= in_valid;
      s1_st <= in_valid && in_start;
      s1_p  <= in_press;
    end
  end

  // Stage 2: pressure-volume and pressure-increment products
  logic                   s2_v, s2_st;
  logic signed [PV_W-1:0] s2_pv;
  logic signed [PD_W-1:0] s2_pdv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_st  <= 1'b0;
      s2_pv  <= '0;
      s2_pdv <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_st  <= s1_st;
      s2_pv  <= PV_W'($signed({1'b0, s1_p})) * PV_W'($signed({1'b0, t_vol}));
      s2_pdv <= PD_W'($signed({1'b0, s1_p})) * PD_W'(t_dvol);
    end
  end

  // Stage 3: running sum and reference
  logic                    s3_v;
  logic signed [PV_W-1:0]  s3_pv, s3_ref;
  logic signed [ACC_W-1:0] s3_acc;

  hr_accum #(.PV_W(PV_W), .PD_W(PD_W), .ACC_W(ACC_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (adv),
    .v_in    (s2_v),
    .start   (s2_st),
    .pv_in   (s2_pv),
    .pdv_in  (s2_pdv),
    .v_out   (s3_v),
    .pv_out  (s3_pv),
    .ref_out (s3_ref),
    .acc_out (s3_acc)
  );

  // Stages 4-6: weights, sum, shift and clip
  logic           core_v;
  logic [Q_W-1:0] core_q;

  hr_scale #(.PV_W(PV_W), .ACC_W(ACC_W), .K_W(K_W), .SUM_W(SUM_W), .SHIFT(SHIFT),
             .Q_W(Q_W), .KA(KA), .KB(KB), .KC(KC)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .v_in   (s3_v),
    .pv_in  (s3_pv),
    .ref_in (s3_ref),
    .acc_in (s3_acc),
    .v_out  (core_v),
    .q_out  (core_q)
  );

  // Delay padding up to the fixed latency
  generate
    if (PAD == 0) begin : g_nopad
      assign out_valid = core_v;
      assign out_heat  = core_q;
    end else begin : g_pad
      logic           pad_v [PAD];
      logic [Q_W-1:0] pad_q [PAD];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < PAD; k++) begin
            pad_v[k] <= 1'b0;
            pad_q[k] <= '0;
          end
        end else if (adv) begin
          pad_v[0] <= core_v;
          pad_q[0] <= core_q;
          for (int k = 1; k < PAD; k++) begin
            pad_v[k] <= pad_v[k-1];
            pad_q[k] <= pad_q[k-1];
          end
        end
      end
      assign out_valid = pad_v[PAD-1];
      assign out_heat  = pad_q[PAD-1];
    end
  endgenerate

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_heat)); // R7
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_heat)); // R3
endmodule

// File: tb/tb_heat_release_pipe.sv
module tb_heat_release_pipe;
  localparam int AW = 6, P_W = 12, V_W = 12, D_W = 12, K_W = 16;
  localparam int ACC_GUARD = 2, SHIFT = 16, LAT = 12, Q_W = 12;
  localparam int KA = 10, KB = 12, KC = 1;
  localparam int ACC_W = P_W + D_W + 1 + ACC_GUARD;
  localparam int N = 1 << AW;
  localparam longint ACC_MAX = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint ACC_MIN = -ACC_MAX - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_start, out_valid, out_ready, tbl_we;
  logic [P_W-1:0] in_press;
  logic [AW-1:0] in_crank, tbl_addr;
  logic [Q_W-1:0] out_heat;
  logic [V_W-1:0] tbl_vol;
  logic signed [D_W-1:0] tbl_dvol;

  heat_release_pipe #(.P_W(P_W), .AW(AW), .V_W(V_W), .D_W(D_W), .K_W(K_W),
    .ACC_GUARD(ACC_GUARD), .SHIFT(SHIFT), .LAT(LAT), .Q_W(Q_W),
    .KA(KA), .KB(KB), .KC(KC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_press(in_press), .in_crank(in_crank), .in_start(in_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_heat(out_heat),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_vol(tbl_vol), .tbl_dvol(tbl_dvol));

  longint tv [N];
  longint tdv [N];
  longint m_ref, m_acc;
  longint exp_q[$];
  int cyc_q[$];
  string tag_q[$];
  string cur_tag;
  int cyc, checks, fails, sent, got, last_stall, stall_mode;
  bit mon_on, prev_hold, seen_hi, seen_lo, acc_hit_hi, acc_hit_lo, done;
  logic [Q_W-1:0] prev_heat;
  logic [15:0] lfsr;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input int p, input int idx, input bit st);
    longint pv, pdv, s, q;
    pv  = longint'(p) * tv[idx];
    pdv = longint'(p) * tdv[idx];
    if (st) begin
      m_ref = pv;
      m_acc = pdv;
    end else begin
      m_acc = m_acc + pdv;
      if (m_acc > ACC_MAX) begin m_acc = ACC_MAX; acc_hit_hi = 1; end
      if (m_acc < ACC_MIN) begin m_acc = ACC_MIN; acc_hit_lo = 1; end
    end
    s = KA * pv - KB * m_ref + KC * m_acc;
    q = s >>> SHIFT;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return q;
  endfunction

  always @(posedge clk) cyc++;

  // Output side: ready pattern, stall hold and value checks
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      longint e;
      int c;
      string t;
      if (prev_hold)
        check(out_valid && out_heat == prev_heat, "R7 hold", longint'($signed(out_heat)),
              longint'($signed(prev_heat)));
      case (stall_mode)
        0: out_ready = 1'b1;
        1: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          out_ready = lfsr[0] | lfsr[3];
        end
        default: out_ready = 1'b0;
      endcase
      if (!out_ready) last_stall = cyc;
      if (out_valid && out_ready) begin
        got++;
        if (exp_q.size() == 0) check(1'b0, "R9 extra result", 1, 0);
        else begin
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          check(longint'($signed(out_heat)) == e, t, longint'($signed(out_heat)), e);
          if (e == 2047) seen_hi = 1;
          if (e == -2048) seen_lo = 1;
          if (c > last_stall) check(cyc - c == LAT, "R2 latency", cyc - c, LAT);
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_heat = out_heat;
    end
  end

  task automatic send(input int p, input int idx, input bit st);
    in_valid = 1'b1; in_press = P_W'(p); in_crank = AW'(idx); in_start = st;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(p, idx, st)); cyc_q.push_back(cyc); tag_q.push_back(cur_tag);
    sent++;
    @(negedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_start = 1'b1; in_press = 12'hfff; in_crank = AW'(7); // R9 junk
    repeat (n) begin @(negedge clk); #1; end
    in_start = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) begin @(negedge clk); #1; end
    check(exp_q.size() == 0, "R7 drain", exp_q.size(), 0);
  endtask

  task automatic wr_tbl(input int i, input longint v, input longint dv);
    tbl_we = 1'b1; tbl_addr = AW'(i); tbl_vol = V_W'(v); tbl_dvol = D_W'(dv);
    tv[i] = v; tdv[i] = dv;
    @(negedge clk); #1;
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int imax, imin;
    rst_n = 0; in_valid = 0; in_start = 0; in_press = 0; in_crank = 0;
    out_ready = 1; tbl_we = 0; tbl_addr = 0; tbl_vol = 0; tbl_dvol = 0;
    lfsr = 16'hace1; last_stall = -1; stall_mode = 0; m_ref = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    check(in_ready == 1, "R1 ready in reset", in_ready, 1);
    rst_n = 1;
    repeat (3) begin @(negedge clk); #1; end
    check(out_valid == 0, "R1 valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 ready after reset", in_ready, 1);

    for (int i = 0; i < N; i++) wr_tbl(i, 200 + 60 * i, ((i * 389) % 4001) - 2000);
    mon_on = 1;

    cur_tag = "R3/R4 sweep";
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < N; i++) begin
        send(((i * 97 + c * 1237) % 4096) >> c, i, i == 0);
        if (i % 7 == 3) idle(2);
      end
    drain();

    cur_tag = "R6 clip";
    send(4095, 63, 1); send(0, 20, 0);
    send(0, 0, 1); send(4095, 63, 0);
    drain();
    check(seen_hi && seen_lo, "R6 both limits", {seen_hi, seen_lo}, 3);

    imax = 0; imin = 0;
    for (int i = 0; i < N; i++) begin
      if (tdv[i] > tdv[imax]) imax = i;
      if (tdv[i] < tdv[imin]) imin = i;
    end
    cur_tag = "R5 sum clip";
    send(10, 0, 1);
    for (int k = 0; k < 40; k++) send(1000, imax, 0);
    for (int k = 0; k < 80; k++) send(1000, imin, 0);
    drain();
    check(acc_hit_hi && acc_hit_lo, "R5 limits reached", {acc_hit_hi, acc_hit_lo}, 3);

    cur_tag = "R8 table rewrite";
    wr_tbl(5, 4000, -2000);
    send(800, 5, 1); send(800, 5, 0); send(3000, 5, 0);
    wr_tbl(5, 100, 1500);
    send(800, 5, 0);
    drain();

    cur_tag = "R7 random stall";
    stall_mode = 1;
    for (int i = 0; i < N; i++) send((i * 211 + 50) % 4096, N - 1 - i, i == 0);
    drain();

    cur_tag = "R7 long stall";
    stall_mode = 2;
    @(negedge clk); #1;
    for (int k = 0; k < 30; k++) begin
      check(in_ready == !out_valid, "R7 ready rule", in_ready, !out_valid);
      if (in_ready) begin
        in_valid = 1; in_press = P_W'(300 + 100 * k); in_crank = AW'(k); in_start = (k == 0);
        exp_q.push_back(model(300 + 100 * k, k, k == 0));
        cyc_q.push_back(cyc); tag_q.push_back(cur_tag); sent++;
      end else begin
        in_valid = 0; in_start = 0;
      end
      @(negedge clk); #1;
    end
    in_valid = 0; in_start = 0;
    stall_mode = 0;
    drain();
    check(sent == got, "R7 one result per sample", got, sent);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule